// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block lets several processors on a chip pass 32-bit words to each other through a set of small hardware queues. It has a number of mailboxes, four by default, and each one owns a queue that holds four words. A processor posts a word by writing the mailbox's message register. A processor takes the oldest word by reading that same register. Per-mailbox registers report whether the queue is full and how many words it holds.

Every mailbox produces two events. A new-message event fires when a word is accepted. A not-full event fires when a read frees a slot in a full queue. Each user (a processor that takes interrupts) has its own latched event status and its own enable mask, and it gets one interrupt line. In the default layout a user writes its enable mask directly. A build-time option gives each user a wider register stride, with separate write-one-to-set and write-one-to-clear views of the mask, so that two agents can change enables without a read-modify-write.

Access is through a single synchronous port. Read data is registered and appears in the cycle after the request.

Top module: `mbx_hub`

## Requirements
- R1: A word written to mailbox m's message register (byte offset 0x040 + 4*m) is returned by later reads of that offset in first-in first-out order.
- R2: Once a mailbox holds 4 words, its full register (0x080 + 4*m) reads 1 and any further write to its message register is discarded; otherwise the full register reads 0.
- R3: A read of an empty mailbox's message register returns 0 and changes no count and no status bit.
- R4: The count register (0x0C0 + 4*m) returns the number of queued words, and 0 when the queue is empty.
- R5: Accepting a word into mailbox m sets bit 2*m of every user's status register.
- R6: A read that takes mailbox m from full to not full sets bit 2*m+1 of every user's status register.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event that arrives in the same cycle as the clear wins over the clear.
- R8: A user's interrupt output is high exactly when some bit is set in both its status and its enable register.
- R9: In the default layout, user u's status register is at 0x100 + 8*u and its enable register at 0x104 + 8*u. The enable register is written directly and reads back its value.
- R10: In the split-enable layout, user u's status register is at 0x104 + 0x10*u. Writing 1s to 0x108 + 0x10*u sets enable bits, and writing 1s to 0x10C + 0x10*u clears them. Both offsets read back the enable mask.
- R11: Offset 0 reads the revision, with the major number in bits 7:4 and the minor number in bits 3:0 (2 and 1 by default).
- R12: After reset all queues are empty and all status and enable registers are zero. An unmapped offset reads 0, and a write to it changes no state.
- R13: Read data appears on the read data output in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 9 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq | output | N_USER | One interrupt line per user |

## Verification
If a queue pointer or count goes wrong, the error shows up at the next read of the count or message register. It appears as a word out of order, a stale word, or a nonzero value where the queue should be empty. If a status bit is latched wrongly, the interrupt line shows it one cycle after the triggering access. Both the status read and the interrupt line are compared against a model that tracks every push, pop and clear. A discarded write or an empty read is checked by reading the count and the queued words right after it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int ADDR_W    = 9;
   localparam int REG_W     = 32;
   localparam int OFS_REV   = 'h000;
   localparam int OFS_MSG   = 'h040;
   localparam int OFS_FULL  = 'h080;
   localparam int OFS_COUNT = 'h0C0;
   localparam int OFS_USER  = 'h100;

   // Write strobes that one user's event bank receives in a cycle
   typedef struct packed {
      logic stat_w1c;
      logic en_wr;
      logic en_clr;
   } usr_wr_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 din,
   output logic [W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]   cnt,
   output logic                         full,
   output logic                         empty,
   output logic                         ev_new,
   output logic                         ev_nf
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign ev_new  = do_push;
   assign ev_nf   = do_pop && full;
   assign head    = mem[rp];
   assign cnt     = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      push && full && !pop |=> full && $stable(wp));
   a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      pop && empty && !push |=> $stable(cnt_q) && $stable(rp));
   a_r6_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
      ev_nf && !push |=> !full);
endmodule

// File: rtl/mbx_irq_user.sv
module mbx_irq_user #(
   parameter int NEV      = 8,
   parameter bit SPLIT_EN = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NEV-1:0]        ev,
   input  mbx_pkg::usr_wr_t      wr,
   input  logic [NEV-1:0]        wdata,
   output logic [NEV-1:0]        stat,
   output logic [NEV-1:0]        en,
   output logic                  irq
);
   logic [NEV-1:0] stat_q, en_q, en_d;

   // Events take priority over a clear landing in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~(wr.stat_w1c ? wdata : '0)) | ev;
   end

   generate
      if (SPLIT_EN) begin : g_split
         always_comb begin
            en_d = en_q;
            if (wr.en_wr)  en_d = en_d | wdata;
            if (wr.en_clr) en_d = en_d & ~wdata;
         end
         a_r10_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
            wr.en_clr && !wr.en_wr |=> ((en_q & $past(wdata)) == '0));
         a_r10_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
            wr.en_wr && !wr.en_clr |=> ((en_q & $past(wdata)) == $past(wdata)));
      end else begin : g_direct
         always_comb begin
            en_d = en_q;
            if (wr.en_wr) en_d = wdata;
         end
         a_r9_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
            wr.en_wr |=> en_q == $past(wdata));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   assign stat = stat_q;
   assign en   = en_q;
   assign irq  = |(stat_q & en_q);

   a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      wr.stat_w1c |=> ((stat_q & $past(wdata & ~ev)) == '0));
   a_r5_r6_event_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev) |=> ((stat_q & $past(ev)) == $past(ev)));
endmodule

// File: rtl/mbx_hub.sv
module mbx_hub #(
   parameter int N_BOX    = 4,
   parameter int DEPTH    = 4,
   parameter int N_USER   = 2,
   parameter bit SPLIT_EN = 1'b0,
   parameter int REV_MAJ  = 2,
   parameter int REV_MIN  = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs,
   input  logic                       we,
   input  logic [mbx_pkg::ADDR_W-1:0] addr,
   input  logic [mbx_pkg::REG_W-1:0]  wdata,
   output logic [mbx_pkg::REG_W-1:0]  rdata,
   output logic [N_USER-1:0]          irq
);
   import mbx_pkg::*;

   localparam int NEV    = 2 * N_BOX;
   localparam int CW     = $clog2(DEPTH + 1);
   localparam int STRIDE = SPLIT_EN ? 'h10 : 'h8;
   localparam int ST_OFS = SPLIT_EN ? 'h4 : 'h0;
   localparam int EN_OFS = SPLIT_EN ? 'h8 : 'h4;
   localparam int CL_OFS = 'hC;
   localparam int WIN    = SPLIT_EN ? 'h130 : 'h120;
   localparam int LAST_U = OFS_USER + STRIDE * (N_USER - 1) + (SPLIT_EN ? CL_OFS : EN_OFS) + 4;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (N_BOX < 1 || 4 * N_BOX > 'h40 || NEV > REG_W) begin : g_bad_box
         $error("N_BOX out of range for the register map");
      end
      if (N_USER < 1 || LAST_U > WIN) begin : g_bad_user
         $error("N_USER does not fit the register window");
      end
      if (REV_MAJ < 0 || REV_MAJ > 15 || REV_MIN < 0 || REV_MIN > 15) begin : g_bad_rev
         $error("revision fields are 4 bits");
      end
   endgenerate

   logic             rd_req, wr_req;
   logic [N_BOX-1:0] msg_hit, full_hit, cnt_hit;
   logic [N_BOX-1:0] full, empty, ev_new, ev_nf;
   logic [REG_W-1:0] head [N_BOX];
   logic [CW-1:0]    cnt  [N_BOX];
   logic [NEV-1:0]   ev;
   logic [N_USER-1:0] st_hit, en_hit, cl_hit;
   logic [NEV-1:0]   stat [N_USER];
   logic [NEV-1:0]   en   [N_USER];
   usr_wr_t          uwr  [N_USER];
   logic [REG_W-1:0] rd_val;

   assign rd_req = cs && !we;
   assign wr_req = cs && we;

   always_comb begin
      for (int m = 0; m < N_BOX; m++) begin
         msg_hit[m]  = (addr == ADDR_W'(OFS_MSG + 4 * m));
         full_hit[m] = (addr == ADDR_W'(OFS_FULL + 4 * m));
         cnt_hit[m]  = (addr == ADDR_W'(OFS_COUNT + 4 * m));
      end
      for (int u = 0; u < N_USER; u++) begin
         st_hit[u] = (addr == ADDR_W'(OFS_USER + STRIDE * u + ST_OFS));
         en_hit[u] = (addr == ADDR_W'(OFS_USER + STRIDE * u + EN_OFS));
         cl_hit[u] = SPLIT_EN && (addr == ADDR_W'(OFS_USER + STRIDE * u + CL_OFS));
      end
   end

   genvar gm, gu;
   generate
      for (gm = 0; gm < N_BOX; gm++) begin : g_box
         mbx_fifo #(.DEPTH(DEPTH), .W(REG_W)) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .push   (wr_req && msg_hit[gm]),
            .pop    (rd_req && msg_hit[gm]),
            .din    (wdata),
            .head   (head[gm]),
            .cnt    (cnt[gm]),
            .full   (full[gm]),
            .empty  (empty[gm]),
            .ev_new (ev_new[gm]),
            .ev_nf  (ev_nf[gm])
         );
         // Interleaved event layout: even bit new word, odd bit slot freed
         assign ev[2*gm]   = ev_new[gm];
         assign ev[2*gm+1] = ev_nf[gm];
      end

      for (gu = 0; gu < N_USER; gu++) begin : g_user
         assign uwr[gu].stat_w1c = wr_req && st_hit[gu];
         assign uwr[gu].en_wr    = wr_req && en_hit[gu];
         assign uwr[gu].en_clr   = wr_req && cl_hit[gu];
         mbx_irq_user #(.NEV(NEV), .SPLIT_EN(SPLIT_EN)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev),
            .wr    (uwr[gu]),
            .wdata (wdata[NEV-1:0]),
            .stat  (stat[gu]),
            .en    (en[gu]),
            .irq   (irq[gu])
         );
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      if (addr == ADDR_W'(OFS_REV))
         rd_val = {{(REG_W-8){1'b0}}, 4'(REV_MAJ), 4'(REV_MIN)};
      for (int m = 0; m < N_BOX; m++) begin
         if (msg_hit[m])  rd_val = empty[m] ? '0 : head[m];
         if (full_hit[m]) rd_val = REG_W'(full[m]);
         if (cnt_hit[m])  rd_val = REG_W'(cnt[m]);
      end
      for (int u = 0; u < N_USER; u++) begin
         if (st_hit[u])              rd_val = REG_W'(stat[u]);
         if (en_hit[u] || cl_hit[u]) rd_val = REG_W'(en[u]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_req) rdata <= rd_val;
   end

   a_r12_no_event_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> ev == '0);
   a_r1_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ev_new | ev_nf) <= 1);
endmodule

// File: tb/mbx_hub_test.sv
module mbx_hub_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs0 = 1'b0, cs1 = 1'b0, we = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata0, rdata1;
   logic [1:0]  irq0, irq1;

   int errors = 0;
   int checks = 0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_issued = 1'b0;
   logic        rd_sel = 1'b0;

   always #2.5 clk = ~clk;

   mbx_hub uut (
      .clk(clk), .rst_n(rst_n), .cs(cs0), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata0), .irq(irq0)
   );

   mbx_hub #(.SPLIT_EN(1'b1)) uut_v (
      .clk(clk), .rst_n(rst_n), .cs(cs1), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata1), .irq(irq1)
   );

   always @(posedge clk) begin
      rd_issued <= (cs0 || cs1) && !we;
      rd_sel    <= cs1;
   end

   // Monitor: compares registered read data against the scoreboard front
   always @(negedge clk) begin
      if (rd_issued) begin
         logic [31:0] e, a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = rd_sel ? rdata1 : rdata0;
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", t, a, e);
         end
      end
   end

   task automatic wr(input bit sel, input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      cs0 = !sel; cs1 = sel; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs0 = 1'b0; cs1 = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input bit sel, input logic [8:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      cs0 = !sel; cs1 = sel; we = 1'b0; addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      cs0 = 1'b0; cs1 = 1'b0;
   endtask

   task automatic chk_irq(input bit sel, input logic [1:0] e, input string t);
      @(negedge clk);
      checks++;
      if ((sel ? irq1 : irq0) !== e) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", t, sel ? irq1 : irq0, e);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state and revision
      chk_irq(0, 2'b00, "R12 irq after reset");
      rd(0, 9'h100, 32'h0, "R12 status reset");
      rd(0, 9'h104, 32'h0, "R12 enable reset");
      rd(0, 9'h0C0, 32'h0, "R12 count reset");
      rd(0, 9'h000, 32'h21, "R11 R13 revision");

      // Default layout: direct enable write
      wr(0, 9'h104, 32'h1);
      rd(0, 9'h104, 32'h1, "R9 enable readback");

      // Fill mailbox 0
      wr(0, 9'h040, 32'hA1);
      chk_irq(0, 2'b01, "R5 R8 new message irq");
      rd(0, 9'h100, 32'h1, "R5 status user0");
      wr(0, 9'h040, 32'hA2);
      wr(0, 9'h040, 32'hA3);
      rd(0, 9'h080, 32'h0, "R2 not full at 3");
      wr(0, 9'h040, 32'hA4);
      rd(0, 9'h080, 32'h1, "R2 full at 4");
      wr(0, 9'h040, 32'hA5);
      rd(0, 9'h0C0, 32'h4, "R2 R4 overflow dropped");

      // Write-one-to-clear
      wr(0, 9'h100, 32'h0);
      rd(0, 9'h100, 32'h1, "R7 zero write keeps");
      wr(0, 9'h100, 32'h1);
      rd(0, 9'h100, 32'h0, "R7 one write clears");
      chk_irq(0, 2'b00, "R8 irq drops");

      // Drain in order
      rd(0, 9'h040, 32'hA1, "R1 pop 1");
      rd(0, 9'h100, 32'h2, "R6 not-full bit");
      rd(0, 9'h0C0, 32'h3, "R4 count 3");
      chk_irq(0, 2'b00, "R8 masked not-full");
      rd(0, 9'h040, 32'hA2, "R1 pop 2");
      rd(0, 9'h040, 32'hA3, "R1 pop 3");
      rd(0, 9'h040, 32'hA4, "R1 pop 4");
      rd(0, 9'h040, 32'h0, "R3 empty read zero");
      rd(0, 9'h0C0, 32'h0, "R3 count stays 0");
      rd(0, 9'h100, 32'h2, "R3 status unchanged");
      rd(0, 9'h108, 32'h3, "R5 R6 user1 status");

      // Mailbox 2 with user1 enable
      wr(0, 9'h048, 32'h55);
      rd(0, 9'h0C8, 32'h1, "R4 box2 count");
      rd(0, 9'h108, 32'h13, "R5 bit 4 user1");
      chk_irq(0, 2'b00, "R8 user1 masked");
      wr(0, 9'h10C, 32'h10);
      chk_irq(0, 2'b10, "R8 user1 enabled");
      rd(0, 9'h048, 32'h55, "R1 box2 pop");

      // Unmapped offsets
      wr(0, 9'h1FC, 32'hFFFF_FFFF);
      rd(0, 9'h1FC, 32'h0, "R12 unmapped read");
      wr(0, 9'h110, 32'hFFFF_FFFF);
      rd(0, 9'h110, 32'h0, "R12 past last user");
      chk_irq(0, 2'b10, "R12 write ignored irq");
      rd(0, 9'h0C0, 32'h0, "R12 no push from unmapped");

      // Split-enable layout
      rd(1, 9'h104, 32'h0, "R10 split status reset");
      wr(1, 9'h108, 32'h3);
      wr(1, 9'h108, 32'h4);
      rd(1, 9'h108, 32'h7, "R10 set accumulates");
      wr(1, 9'h10C, 32'h2);
      rd(1, 9'h108, 32'h5, "R10 clear bit");
      rd(1, 9'h10C, 32'h5, "R10 clear view reads mask");
      wr(1, 9'h040, 32'hBEEF);
      chk_irq(1, 2'b01, "R10 R8 split irq");
      wr(1, 9'h10C, 32'h1);
      chk_irq(1, 2'b00, "R10 cleared enable");
      rd(1, 9'h104, 32'h1, "R10 status kept");
      rd(1, 9'h100, 32'h0, "R12 split unmapped");
      rd(1, 9'h114, 32'h1, "R10 user1 status");
      rd(1, 9'h040, 32'hBEEF, "R1 split pop");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual=%0d expected=0", exp_q.size());
      end
      finish_run();
   end
endmodule